// File: doc/BRIEF.md
# Store Access Sequencer

This block carries a single processor store (byte, halfword or word) through the memory management path. A store is accepted when the block is idle. Its virtual address, data, size code and three configuration flags (translation on, alignment checking on, write buffering on) are captured at that moment. The block then talks, one at a time, to an instruction cache, an address translator, a permission checker, a main data cache, a mini data cache, a write buffer and main memory. Each of these units sits behind its own request/acknowledge pair. When the store has finished, the block reports a one-cycle completion pulse with a 4-bit fault code, or with an error flag.

The instruction cache is always probed first. With translation off, the store then goes straight to memory. With translation on, the address is checked for alignment and word-aligned before it is translated and checked for permission. The two data caches are then probed in order. A store that misses both caches is either posted to the write buffer or written to memory directly; a direct write to a non-bufferable page first empties the write buffer.

States: `S_IDLE`, `S_ICACHE`, `S_XLATE`, `S_PERM`, `S_MAIN`, `S_MINI`, `S_WBUF`, `S_DRAIN`, `S_MEM`, `S_RESP`. Transitions:
- `S_IDLE`→`S_ICACHE` on a valid store. `S_IDLE`→`S_RESP` on a bad size code.
- `S_ICACHE`→`S_MEM` when translation is off. `S_ICACHE`→`S_RESP` on misalignment. `S_ICACHE`→`S_XLATE` otherwise.
- `S_XLATE`→`S_RESP` on a translation fault, `S_XLATE`→`S_PERM` otherwise.
- `S_PERM`→`S_RESP` on a permission fault, `S_PERM`→`S_MAIN` otherwise.
- `S_MAIN`→`S_RESP` on a hit, `S_MAIN`→`S_MINI` on a miss.
- `S_MINI`→`S_RESP` on a hit. On a miss, `S_MINI` goes to `S_WBUF` (bufferable page, buffering on), to `S_MEM` (bufferable page, buffering off) or to `S_DRAIN` (non-bufferable page).
- `S_DRAIN`→`S_MEM`, `S_WBUF`→`S_RESP`, `S_MEM`→`S_RESP`, `S_RESP`→`S_IDLE`.

Top module: `store_dispatch`

## Requirements
- R1: After reset the block is idle: `st_ready` is 1, `st_done` is 0 and no unit request is active.
- R2: Every store with a valid size first requests the instruction cache, presenting the full, unaligned virtual address on `cq_addr`. A hit there does not end the store.
- R3: With translation off, the instruction cache probe is followed directly by a memory write at the unaligned virtual address, with the given size and data, and fault code 0. No alignment check is made.
- R4: With alignment checking on, two cases end the store with fault code 1 right after the instruction cache probe: a word store (size 2) whose address bits 1:0 are nonzero, and a halfword store (size 1) whose address bit 0 is set. With checking off, or when the address is aligned, the store proceeds.
- R5: The address given to translation and permission checking is the virtual address with bits 1:0 cleared.
- R6: A nonzero translation fault code ends the store with that code, and permission checking is skipped. A nonzero permission fault code ends the store with that code, and no data cache is probed.
- R7: The main data cache is probed first. The mini data cache is probed only after a main miss. A hit in either ends the store with fault 0 and no write.
- R8: A store that misses both caches and goes to a bufferable page is sent to the write buffer when buffering is on. When buffering is off, it is written to memory without a drain.
- R9: A store that misses both caches and goes to a non-bufferable page requests a full write-buffer drain and, after the drain completes, a memory write.
- R10: The write address after translation depends on the size. A word store uses the physical address. A halfword store uses the physical address OR virtual bit 1 (in bit position 1). A byte store uses the physical address OR virtual bits 1:0.
- R11: Size code 3 is invalid. It produces `st_done` with `st_err` = 1 and fault 0, and requests no unit.
- R12: At most one unit request is active at a time. `st_done` lasts exactly one cycle. A start presented while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Start a store (taken only when ready) |
| st_ready | output | 1 | Block idle, store can be accepted |
| st_addr | input | AW | Virtual address of the store |
| st_data | input | DW | Store data |
| st_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| cfg_mmu_on | input | 1 | Translation enabled |
| cfg_align_chk | input | 1 | Alignment checking enabled |
| cfg_wbuf_on | input | 1 | Write buffering enabled |
| st_done | output | 1 | One-cycle completion pulse |
| st_fault | output | FW | Fault code, valid with st_done |
| st_err | output | 1 | Invalid size, valid with st_done |
| cq_addr | output | AW | Cache address: full VA for the instruction cache, word-aligned VA for the data caches |
| cq_off | output | 2 | Virtual address bits 1:0 for sub-word merge |
| cq_data | output | DW | Cache write data |
| cq_size | output | 2 | Cache write size |
| ic_req | output | 1 | Instruction cache probe/update request |
| ic_ack | input | 1 | Instruction cache acknowledge |
| ic_hit | input | 1 | Instruction cache hit (updated) |
| tr_req | output | 1 | Translation request |
| tr_addr | output | AW | Word-aligned VA for translation and permission |
| tr_ack | input | 1 | Translation acknowledge |
| tr_fault | input | FW | Translation fault code, 0 = none |
| tr_pa | input | AW | Physical address |
| tr_bufable | input | 1 | Page is bufferable |
| pc_req | output | 1 | Permission check request |
| pc_ack | input | 1 | Permission check acknowledge |
| pc_fault | input | FW | Permission fault code, 0 = none |
| dmain_req | output | 1 | Main data cache probe/update request |
| dmain_ack | input | 1 | Main data cache acknowledge |
| dmain_hit | input | 1 | Main data cache hit |
| dmini_req | output | 1 | Mini data cache probe/update request |
| dmini_ack | input | 1 | Mini data cache acknowledge |
| dmini_hit | input | 1 | Mini data cache hit |
| wb_req | output | 1 | Write buffer post request |
| wb_ack | input | 1 | Write buffer acknowledge |
| wb_drain_req | output | 1 | Write buffer full-drain request |
| wb_drain_ack | input | 1 | Drain complete |
| mem_req | output | 1 | Direct memory write request |
| mem_ack | input | 1 | Memory acknowledge |
| wr_addr | output | AW | Write address for buffer or memory |
| wr_data | output | DW | Write data for buffer or memory |
| wr_size | output | 2 | Write size for buffer or memory |

## Verification
The stores are chosen so that each one ends at a different point in the state sequence. Some hit the main cache, some hit the mini cache, and the rest miss both and are posted, written directly, or drained and then written; others end early with an alignment, translation or permission fault, or take the path with translation off. Comparing the full ordered list of units requested shows whether a lookup was skipped, repeated or reordered, for example the mini cache before the main cache, or the memory write before the drain. Byte, halfword and word stores at each low-address offset separate the three write-address formations and the alignment rules. One store with the alignment check off, at an offset that would otherwise fault, shows that the check is gated by its flag.

// File: rtl/store_dispatch_pkg.sv
package store_dispatch_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    localparam int unsigned FAULT_W = 4;
    localparam logic [FAULT_W-1:0] FLT_NONE  = 4'd0;
    localparam logic [FAULT_W-1:0] FLT_ALIGN = 4'd1;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_ICACHE = 4'd1,
        S_XLATE  = 4'd2,
        S_PERM   = 4'd3,
        S_MAIN   = 4'd4,
        S_MINI   = 4'd5,
        S_WBUF   = 4'd6,
        S_DRAIN  = 4'd7,
        S_MEM    = 4'd8,
        S_RESP   = 4'd9
    } dsp_state_e;

endpackage

// File: rtl/store_align_chk.sv
module store_align_chk
    import store_dispatch_pkg::*;
(
    input  logic       chk_on,
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       misaligned
);
    logic word_bad;
    logic half_bad;

    always_comb begin
        word_bad   = (size == SZ_WORD) && (addr_lo != 2'b00);
        half_bad   = (size == SZ_HALF) && addr_lo[0];
        misaligned = chk_on && (word_bad || half_bad);
    end
endmodule

// File: rtl/store_addr_form.sv
module store_addr_form
    import store_dispatch_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] pa,
    input  logic [1:0]    va_lo,
    input  logic [1:0]    size,
    output logic [AW-1:0] wr_pa
);
    localparam int unsigned HI_W = AW - 2;

    logic [1:0] lane;

    always_comb begin
        unique case (size)
            SZ_HALF: lane = {va_lo[1], 1'b0};
            SZ_BYTE: lane = va_lo;
            default: lane = 2'b00;
        endcase
        wr_pa = pa | {{HI_W{1'b0}}, lane};
    end
endmodule

// File: rtl/store_dispatch.sv
module store_dispatch
    import store_dispatch_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned FW = FAULT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [1:0]    st_size,
    input  logic          cfg_mmu_on,
    input  logic          cfg_align_chk,
    input  logic          cfg_wbuf_on,
    output logic          st_done,
    output logic [FW-1:0] st_fault,
    output logic          st_err,
    output logic [AW-1:0] cq_addr,
    output logic [1:0]    cq_off,
    output logic [DW-1:0] cq_data,
    output logic [1:0]    cq_size,
    output logic          ic_req,
    input  logic          ic_ack,
    input  logic          ic_hit,
    output logic          tr_req,
    output logic [AW-1:0] tr_addr,
    input  logic          tr_ack,
    input  logic [FW-1:0] tr_fault,
    input  logic [AW-1:0] tr_pa,
    input  logic          tr_bufable,
    output logic          pc_req,
    input  logic          pc_ack,
    input  logic [FW-1:0] pc_fault,
    output logic          dmain_req,
    input  logic          dmain_ack,
    input  logic          dmain_hit,
    output logic          dmini_req,
    input  logic          dmini_ack,
    input  logic          dmini_hit,
    output logic          wb_req,
    input  logic          wb_ack,
    output logic          wb_drain_req,
    input  logic          wb_drain_ack,
    output logic          mem_req,
    input  logic          mem_ack,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [1:0]    wr_size
);
    localparam int unsigned HI_W = AW - 2;

    dsp_state_e    state, nxt_state;

    logic [AW-1:0] va_q;
    logic [DW-1:0] data_q;
    logic [1:0]    size_q;
    logic          mmu_q, chk_q, wben_q;
    logic [AW-1:0] pa_q;
    logic          buf_q;
    logic [FW-1:0] fault_q, nxt_fault;
    logic          err_q, nxt_err;
    logic          fault_set;

    logic          misaligned;
    logic [AW-1:0] formed_pa;
    logic [AW-1:0] va_word;

    assign va_word = {va_q[AW-1:2], 2'b00};

    store_align_chk u_align (
        .chk_on     (chk_q),
        .addr_lo    (va_q[1:0]),
        .size       (size_q),
        .misaligned (misaligned)
    );

    store_addr_form #(.AW(AW)) u_addr (
        .pa    (pa_q),
        .va_lo (va_q[1:0]),
        .size  (size_q),
        .wr_pa (formed_pa)
    );

    // next-state and result selection
    always_comb begin
        nxt_state = state;
        nxt_fault = FLT_NONE;
        nxt_err   = 1'b0;
        fault_set = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (st_valid) begin
                    fault_set = 1'b1;
                    if (st_size == SZ_BAD) begin
                        nxt_err   = 1'b1;
                        nxt_state = S_RESP;
                    end else begin
                        nxt_state = S_ICACHE;
                    end
                end
            end
            S_ICACHE: begin
                if (ic_ack) begin
                    if (!mmu_q) begin
                        nxt_state = S_MEM;
                    end else if (misaligned) begin
                        fault_set = 1'b1;
                        nxt_fault = FLT_ALIGN;
                        nxt_state = S_RESP;
                    end else begin
                        nxt_state = S_XLATE;
                    end
                end
            end
            S_XLATE: begin
                if (tr_ack) begin
                    if (tr_fault != FLT_NONE) begin
                        fault_set = 1'b1;
                        nxt_fault = tr_fault;
                        nxt_state = S_RESP;
                    end else begin
                        nxt_state = S_PERM;
                    end
                end
            end
            S_PERM: begin
                if (pc_ack) begin
                    if (pc_fault != FLT_NONE) begin
                        fault_set = 1'b1;
                        nxt_fault = pc_fault;
                        nxt_state = S_RESP;
                    end else begin
                        nxt_state = S_MAIN;
                    end
                end
            end
            S_MAIN: begin
                if (dmain_ack) begin
                    nxt_state = dmain_hit ? S_RESP : S_MINI;
                end
            end
            S_MINI: begin
                if (dmini_ack) begin
                    if (dmini_hit)       nxt_state = S_RESP;
                    else if (!buf_q)     nxt_state = S_DRAIN;
                    else if (wben_q)     nxt_state = S_WBUF;
                    else                 nxt_state = S_MEM;
                end
            end
            S_WBUF:  if (wb_ack)       nxt_state = S_RESP;
            S_DRAIN: if (wb_drain_ack) nxt_state = S_MEM;
            S_MEM:   if (mem_ack)      nxt_state = S_RESP;
            S_RESP:  nxt_state = S_IDLE;
            default: nxt_state = S_IDLE;
        endcase
    end

    // state register and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            va_q    <= '0;
            data_q  <= '0;
            size_q  <= SZ_BYTE;
            mmu_q   <= 1'b0;
            chk_q   <= 1'b0;
            wben_q  <= 1'b0;
            pa_q    <= '0;
            buf_q   <= 1'b0;
            fault_q <= FLT_NONE;
            err_q   <= 1'b0;
        end else begin
            state <= nxt_state;
            if (state == S_IDLE && st_valid) begin
                va_q   <= st_addr;
                data_q <= st_data;
                size_q <= st_size;
                mmu_q  <= cfg_mmu_on;
                chk_q  <= cfg_align_chk;
                wben_q <= cfg_wbuf_on;
                err_q  <= nxt_err;
            end
            if (state == S_XLATE && tr_ack) begin
                pa_q  <= tr_pa;
                buf_q <= tr_bufable;
            end
            if (fault_set) begin
                fault_q <= nxt_fault;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        st_ready     = (state == S_IDLE);
        st_done      = (state == S_RESP);
        st_fault     = (state == S_RESP) ? fault_q : FLT_NONE;
        st_err       = (state == S_RESP) && err_q;
        ic_req       = (state == S_ICACHE);
        tr_req       = (state == S_XLATE);
        pc_req       = (state == S_PERM);
        dmain_req    = (state == S_MAIN);
        dmini_req    = (state == S_MINI);
        wb_req       = (state == S_WBUF);
        wb_drain_req = (state == S_DRAIN);
        mem_req      = (state == S_MEM);
        cq_addr      = (state == S_ICACHE) ? va_q : va_word;
        cq_off       = va_q[1:0];
        cq_data      = data_q;
        cq_size      = size_q;
        tr_addr      = {va_q[AW-1:2], {2{1'b0}}};
        wr_addr      = mmu_q ? formed_pa : va_q;
        wr_data      = data_q;
        wr_size      = size_q;
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = va_word[AW-1:2];
endmodule

// File: rtl/store_dispatch_chk.sv
module store_dispatch_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned FW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_done,
    input logic          st_err,
    input logic [FW-1:0] st_fault,
    input logic          ic_req,
    input logic          ic_ack,
    input logic          tr_req,
    input logic          tr_ack,
    input logic [AW-1:0] tr_addr,
    input logic          pc_req,
    input logic          dmain_req,
    input logic          dmain_ack,
    input logic          dmain_hit,
    input logic          dmini_req,
    input logic          wb_req,
    input logic          wb_drain_req,
    input logic          mem_req
);
    assert_one_unit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ic_req, tr_req, pc_req, dmain_req, dmini_req, wb_req, wb_drain_req, mem_req}));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |=> !st_done);

    assert_word_xlate_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tr_req |-> (tr_addr[1:0] == 2'b00));

    assert_err_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> (st_done && st_fault == '0));

    assert_icache_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tr_req) |-> $past(ic_ack));

    assert_perm_after_xlate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pc_req) |-> $past(tr_ack));

    assert_mini_after_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmini_req) |-> $past(dmain_ack && !dmain_hit));
endmodule

bind store_dispatch store_dispatch_chk #(.AW(AW), .FW(FW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_done      (st_done),
    .st_err       (st_err),
    .st_fault     (st_fault),
    .ic_req       (ic_req),
    .ic_ack       (ic_ack),
    .tr_req       (tr_req),
    .tr_ack       (tr_ack),
    .tr_addr      (tr_addr),
    .pc_req       (pc_req),
    .dmain_req    (dmain_req),
    .dmain_ack    (dmain_ack),
    .dmain_hit    (dmain_hit),
    .dmini_req    (dmini_req),
    .wb_req       (wb_req),
    .wb_drain_req (wb_drain_req),
    .mem_req      (mem_req)
);

// File: tb/store_dispatch_bench.sv
`timescale 1ns/1ps
module store_dispatch_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int FW = 4;

    localparam logic [3:0] U_IC = 4'd1, U_TR = 4'd2, U_PC = 4'd3, U_MAIN = 4'd4,
                           U_MINI = 4'd5, U_WB = 4'd6, U_DRN = 4'd7, U_MEM = 4'd8;

    typedef struct packed {
        logic [1:0]  size;
        logic [31:0] addr;
        logic        mmu;
        logic        chk;
        logic        wben;
        logic        ich;
        logic        mh;
        logic        nh;
        logic        bf;
        logic [3:0]  trf;
        logic [3:0]  pcf;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 32'h1000_0100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 32'h8000_1000},
        '{2'd1, 32'h1000_0106, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 32'h8000_2000},
        '{2'd0, 32'h1000_0203, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 32'h8000_3000},
        '{2'd0, 32'h2000_0003, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 32'h0000_0000},
        '{2'd2, 32'h1000_0302, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 32'h8000_4000},
        '{2'd1, 32'h1000_0401, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 32'h8000_5000},
        '{2'd1, 32'h1000_0502, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 32'h8000_6000},
        '{2'd2, 32'h1000_0601, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0, 32'h8000_7000},
        '{2'd2, 32'h1000_0700, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 4'd0, 32'h8000_8000},
        '{2'd2, 32'h1000_0800, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd9, 32'h8000_9000},
        '{2'd3, 32'h1000_0900, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 32'h8000_A000},
        '{2'd2, 32'h1000_0A00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 32'h8000_B000},
        '{2'd0, 32'h1000_0B02, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 32'h8000_C000}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R8";
            1:       return "R10";
            2:       return "R9";
            3:       return "R3";
            4, 5:    return "R4";
            6:       return "R7";
            7:       return "R4";
            8, 9:    return "R6";
            10:      return "R11";
            11:      return "R2";
            default: return "R10";
        endcase
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [1:0]    st_size = 2'd0;
    logic          cfg_mmu_on = 1'b0, cfg_align_chk = 1'b0, cfg_wbuf_on = 1'b0;
    logic          st_done;
    logic [FW-1:0] st_fault;
    logic          st_err;
    logic [AW-1:0] cq_addr;
    logic [1:0]    cq_off;
    logic [DW-1:0] cq_data;
    logic [1:0]    cq_size;
    logic          ic_req, tr_req, pc_req, dmain_req, dmini_req, wb_req, wb_drain_req, mem_req;
    logic          ic_ack = 0, tr_ack = 0, pc_ack = 0, dmain_ack = 0, dmini_ack = 0;
    logic          wb_ack = 0, wb_drain_ack = 0, mem_ack = 0;
    logic [AW-1:0] tr_addr, wr_addr;
    logic [DW-1:0] wr_data;
    logic [1:0]    wr_size;

    vec_t cv = '0;
    logic          ic_hit, tr_bufable, dmain_hit, dmini_hit;
    logic [FW-1:0] tr_fault, pc_fault;
    logic [AW-1:0] tr_pa;
    assign ic_hit     = cv.ich;
    assign tr_bufable = cv.bf;
    assign dmain_hit  = cv.mh;
    assign dmini_hit  = cv.nh;
    assign tr_fault   = cv.trf;
    assign pc_fault   = cv.pcf;
    assign tr_pa      = cv.pa;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    store_dispatch #(.AW(AW), .DW(DW), .FW(FW)) u_store_dispatch (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_size(st_size),
        .cfg_mmu_on(cfg_mmu_on), .cfg_align_chk(cfg_align_chk), .cfg_wbuf_on(cfg_wbuf_on),
        .st_done(st_done), .st_fault(st_fault), .st_err(st_err),
        .cq_addr(cq_addr), .cq_off(cq_off), .cq_data(cq_data), .cq_size(cq_size),
        .ic_req(ic_req), .ic_ack(ic_ack), .ic_hit(ic_hit),
        .tr_req(tr_req), .tr_addr(tr_addr), .tr_ack(tr_ack), .tr_fault(tr_fault),
        .tr_pa(tr_pa), .tr_bufable(tr_bufable),
        .pc_req(pc_req), .pc_ack(pc_ack), .pc_fault(pc_fault),
        .dmain_req(dmain_req), .dmain_ack(dmain_ack), .dmain_hit(dmain_hit),
        .dmini_req(dmini_req), .dmini_ack(dmini_ack), .dmini_hit(dmini_hit),
        .wb_req(wb_req), .wb_ack(wb_ack), .wb_drain_req(wb_drain_req), .wb_drain_ack(wb_drain_ack),
        .mem_req(mem_req), .mem_ack(mem_ack),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size)
    );

    // unit responders: acknowledge one negedge after a request, log the order
    logic [63:0]   seq_log = '0;
    int            n_log = 0;
    logic [AW-1:0] ic_addr_log = '0, tr_addr_log = '0, wr_addr_log = '0;
    logic [DW-1:0] wr_data_log = '0;
    logic [1:0]    wr_size_log = '0;

    task automatic note(input logic [3:0] id);
        seq_log = {seq_log[59:0], id};
        n_log   = n_log + 1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ic_req && !ic_ack)          begin note(U_IC);   ic_addr_log = cq_addr; end
            if (tr_req && !tr_ack)          begin note(U_TR);   tr_addr_log = tr_addr; end
            if (pc_req && !pc_ack)          note(U_PC);
            if (dmain_req && !dmain_ack)    note(U_MAIN);
            if (dmini_req && !dmini_ack)    note(U_MINI);
            if (wb_drain_req && !wb_drain_ack) note(U_DRN);
            if ((wb_req && !wb_ack) || (mem_req && !mem_ack)) begin
                note(wb_req ? U_WB : U_MEM);
                wr_addr_log = wr_addr;
                wr_data_log = wr_data;
                wr_size_log = wr_size;
            end
        end
        ic_ack       <= rst_n && ic_req && !ic_ack;
        tr_ack       <= rst_n && tr_req && !tr_ack;
        pc_ack       <= rst_n && pc_req && !pc_ack;
        dmain_ack    <= rst_n && dmain_req && !dmain_ack;
        dmini_ack    <= rst_n && dmini_req && !dmini_ack;
        wb_ack       <= rst_n && wb_req && !wb_ack;
        wb_drain_ack <= rst_n && wb_drain_req && !wb_drain_ack;
        mem_ack      <= rst_n && mem_req && !mem_ack;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input vec_t v, output logic [63:0] seq, output int len,
                         output logic [3:0] flt, output bit err, output bit wr,
                         output logic [31:0] waddr, output bit tr_used);
        seq = '0; len = 0; flt = 4'd0; err = 0; wr = 0; waddr = '0; tr_used = 0;
        if (v.size == 2'd3) begin err = 1; return; end
        seq = {60'd0, U_IC}; len = 1;
        if (!v.mmu) begin
            seq = {seq[59:0], U_MEM}; len++; wr = 1; waddr = v.addr; return;
        end
        if (v.chk && ((v.size == 2'd2 && v.addr[1:0] != 0) || (v.size == 2'd1 && v.addr[0]))) begin
            flt = 4'd1; return;
        end
        seq = {seq[59:0], U_TR}; len++; tr_used = 1;
        if (v.trf != 0) begin flt = v.trf; return; end
        seq = {seq[59:0], U_PC}; len++;
        if (v.pcf != 0) begin flt = v.pcf; return; end
        seq = {seq[59:0], U_MAIN}; len++;
        if (v.mh) return;
        seq = {seq[59:0], U_MINI}; len++;
        if (v.nh) return;
        wr = 1;
        case (v.size)
            2'd0:    waddr = v.pa | {30'd0, v.addr[1:0]};
            2'd1:    waddr = v.pa | {30'd0, v.addr[1], 1'b0};
            default: waddr = v.pa;
        endcase
        if (!v.bf) begin
            seq = {seq[59:0], U_DRN}; len++;
            seq = {seq[59:0], U_MEM}; len++;
        end else if (v.wben) begin
            seq = {seq[59:0], U_WB}; len++;
        end else begin
            seq = {seq[59:0], U_MEM}; len++;
        end
    endtask

    task automatic start(input vec_t v);
        cv            = v;
        st_addr       = v.addr;
        st_data       = ~v.addr;
        st_size       = v.size;
        cfg_mmu_on    = v.mmu;
        cfg_align_chk = v.chk;
        cfg_wbuf_on   = v.wben;
        st_valid      = 1'b1;
        @(negedge clk);
        st_valid      = 1'b0;
    endtask

    task automatic wait_done(output bit seen, output logic [3:0] flt, output bit err);
        seen = 0; flt = '0; err = 0;
        for (int i = 0; i < 200; i++) begin
            if (st_done) begin seen = 1; flt = st_fault; err = st_err; break; end
            @(negedge clk);
        end
    endtask

    task automatic evaluate(input vec_t v, input string tag, input int cnt0);
        logic [63:0] eseq, gseq;
        int          elen, glen;
        logic [3:0]  eflt, gflt;
        bit          eerr, gerr, ewr, etr, seen;
        logic [31:0] ewa;
        model(v, eseq, elen, eflt, eerr, ewr, ewa, etr);
        wait_done(seen, gflt, gerr);
        check(seen, tag, "done seen", {63'd0, seen}, 64'd1);
        glen = n_log - cnt0;
        gseq = (glen == 0) ? 64'd0 : (seq_log & ((64'd1 << (4 * glen)) - 64'd1));
        check(glen == elen && gseq == eseq, tag, "unit order", gseq, eseq);
        check(gflt == eflt, tag, "fault code", {60'd0, gflt}, {60'd0, eflt});
        check(gerr == eerr, tag, "error flag", {63'd0, gerr}, {63'd0, eerr});
        if (!eerr)
            check(ic_addr_log == v.addr, "R2", "icache address", {32'd0, ic_addr_log}, {32'd0, v.addr});
        if (etr)
            check(tr_addr_log == {v.addr[31:2], 2'b00}, "R5", "translate address",
                  {32'd0, tr_addr_log}, {32'd0, v.addr[31:2], 2'b00});
        if (ewr) begin
            check(wr_addr_log == ewa, tag, "write address", {32'd0, wr_addr_log}, {32'd0, ewa});
            check(wr_size_log == v.size && wr_data_log == ~v.addr, tag, "write size/data",
                  {30'd0, wr_size_log}, {30'd0, v.size});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(st_ready && !st_done && !st_err, "R1", "idle after reset",
              {61'd0, st_ready, st_done, st_err}, 64'h4);
        check({ic_req, tr_req, pc_req, dmain_req, dmini_req, wb_req, wb_drain_req, mem_req} == 8'd0,
              "R1", "no requests", {56'd0, ic_req, tr_req, pc_req, dmain_req, dmini_req,
              wb_req, wb_drain_req, mem_req}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            int c0;
            c0 = n_log;
            start(VECS[i]);
            evaluate(VECS[i], vec_tag(i), c0);
            @(negedge clk);
        end

        // R12: start while busy ignored, done is a single-cycle pulse
        begin
            int c0;
            c0 = n_log;
            start(VECS[0]);
            @(negedge clk);
            check(!st_ready, "R12", "not ready while busy", {63'd0, st_ready}, 64'd0);
            st_size  = 2'd3;
            st_valid = 1'b1;
            @(negedge clk);
            st_valid = 1'b0;
            evaluate(VECS[0], "R12", c0);
            @(negedge clk);
            check(!st_done, "R12", "done one cycle", {63'd0, st_done}, 64'd0);
            check(st_ready, "R12", "idle after done", {63'd0, st_ready}, 64'd1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule